// File: doc/BRIEF.md
# Two-Segment Boot Copy Engine

This block runs once after reset. It copies code out of a slow source memory into fast internal RAM and then passes control to the copied program. Before the first copy it raises an interrupt-mask output. It then copies a fixed-origin interrupt vector table to a relocated base, and after that the user program segment from its stored base to its run-time base. Each segment has its own source, destination and word count.

When both copies are complete, the engine sets the overlay bit in a processor-mode configuration register. Internal RAM then appears in program space as well as data space. In the next cycle the engine presents the program's run-time base as the new program-counter value, together with a one-cycle valid strobe. After that it stays quiet until the next reset.

The source memory is a synchronous read port with one clock of latency. The destination is a simple write port. The segment bases and lengths are static inputs that are held stable while reset is released.

Top module: `boot_mover`

## Requirements
- R1: During reset, `src_rd_en`, `dst_wr_en` and `jump_valid` are 0, `irq_mask` is 0 and `mode_cfg` holds the parameter `CFG_INIT`.
- R2: `irq_mask` becomes 1 in the first cycle after reset release. It is 1 in every cycle in which a read is issued.
- R3: The vector phase reads `vec_len` words, one per cycle, from addresses `VEC_SRC` (default 0xFF80), +1, +2 and so on in order. It writes them to `vec_dst`, +1 and so on in the same order.
- R4: The program phase reads `prg_len` words from `prg_src` upward and writes them to `prg_dst` upward. Its first read comes only after the vector phase has issued its last write.
- R5: Every word is written exactly two cycles after its read is issued, one cycle after the source returns it. The written data equals the word returned by the source.
- R6: A phase with a length of 0 issues no reads and no writes and takes one cycle. A phase of N > 0 words takes N + 3 cycles from its start cycle to its completion cycle.
- R7: After the last write, bit 5 (mask 0x20) of `mode_cfg` is set and every other bit keeps its `CFG_INIT` value. Before that, `mode_cfg` does not change.
- R8: `jump_valid` is high for exactly one cycle, with `jump_pc` equal to `prg_dst`, and the overlay bit is already visible in that cycle. Counting the first cycle after reset release as cycle 0, the strobe falls in cycle 4 + d(vec_len) + d(prg_len), where d(0) = 1 and d(N) = N + 3.
- R9: After the jump strobe, no read, write or further strobe occurs until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_dst | input | ADDR_W | Relocated base of the vector table |
| vec_len | input | LEN_W | Vector table length in words |
| prg_src | input | ADDR_W | Stored base of the user program |
| prg_dst | input | ADDR_W | Run-time base of the user program |
| prg_len | input | LEN_W | User program length in words |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | ADDR_W | Source read address |
| src_rd_data | input | DATA_W | Source data, valid one cycle after the request |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | ADDR_W | Destination write address |
| dst_wr_data | output | DATA_W | Destination write data |
| mode_cfg | output | CFG_W | Processor-mode configuration register |
| irq_mask | output | 1 | Interrupt mask, high while booting |
| jump_valid | output | 1 | One-cycle jump strobe |
| jump_pc | output | ADDR_W | Program-counter target, valid with the strobe |

## Verification
The faults that matter are a corrupted pointer or remaining-word counter, or a sequencer that steps to the wrong phase. A bad pointer shows up at once as a wrong address on the first read or write it touches. A bad counter changes the number of accesses and moves the jump strobe away from its computed cycle. A wrong phase order overlaps the two segments' traffic or sets the overlay bit too early, so a snapshot of `mode_cfg` taken during copying differs from `CFG_INIT`. The bench sweeps every pair of short lengths, including zero. It compares every access against arithmetic expectations and checks the exact cycle of the jump strobe.

// File: rtl/boot_mover_pkg.sv
// Package: shared types for the boot copy engine.
// Assumes: one sequencer walks these phases in the declared order.
package boot_mover_pkg;

    typedef enum logic [2:0] {
        PH_MASK   = 3'd0,
        PH_VEC_GO = 3'd1,
        PH_VEC    = 3'd2,
        PH_PRG_GO = 3'd3,
        PH_PRG    = 3'd4,
        PH_OVLY   = 3'd5,
        PH_JUMP   = 3'd6,
        PH_IDLE   = 3'd7
    } boot_phase_e;

endpackage

// File: rtl/boot_mover_seq.sv
// Module: boot_mover_seq
// Walks the fixed boot script: mask interrupts, copy vectors, copy program,
// set overlay, jump, then idle. Assumes xfer_done pulses once per started copy.
module boot_mover_seq
    import boot_mover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_done,
    output logic xfer_start,
    output logic sel_prg,
    output logic set_ovly,
    output logic jump_now,
    output logic irq_mask
);

    boot_phase_e phase_q, phase_d;

    // Next-phase selection for the ordered script.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_MASK:   phase_d = PH_VEC_GO;
            PH_VEC_GO: phase_d = PH_VEC;
            PH_VEC:    if (xfer_done) phase_d = PH_PRG_GO;
            PH_PRG_GO: phase_d = PH_PRG;
            PH_PRG:    if (xfer_done) phase_d = PH_OVLY;
            PH_OVLY:   phase_d = PH_JUMP;
            PH_JUMP:   phase_d = PH_IDLE;
            PH_IDLE:   phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register and interrupt-mask flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_MASK;
            irq_mask <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_MASK) begin
                irq_mask <= 1'b1;
            end
        end
    end

    // Phase-decoded control strobes.
    always_comb begin
        xfer_start = (phase_q == PH_VEC_GO) || (phase_q == PH_PRG_GO);
        sel_prg    = (phase_q == PH_PRG_GO) || (phase_q == PH_PRG);
        set_ovly   = (phase_q == PH_OVLY);
        jump_now   = (phase_q == PH_JUMP);
    end

endmodule

// File: rtl/boot_mover_xfer.sv
// Module: boot_mover_xfer
// Copies len words from src upward to dst upward, one read per cycle.
// Assumes the source returns data one cycle after the request. Each write is
// issued one cycle after its data returns. done pulses once, when all writes
// have drained. A zero length completes in the cycle after start.
module boot_mover_xfer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [LEN_W-1:0]  len,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic              busy_q;
    logic [LEN_W-1:0]  remain_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [ADDR_W-1:0] wr_ptr_q;
    logic              ret_q;
    logic              wr_q;
    logic [DATA_W-1:0] data_q;

    // Issue and drain conditions.
    always_comb begin
        rd_en = busy_q && (remain_q != '0);
        done  = busy_q && (remain_q == '0) && !ret_q && !wr_q;
    end

    // Pointers, word counter and the two-stage read-to-write pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            ret_q    <= 1'b0;
            wr_q     <= 1'b0;
            data_q   <= '0;
        end else begin
            ret_q <= rd_en;
            wr_q  <= ret_q;
            if (ret_q) begin
                data_q <= rd_data;
            end
            if (start) begin
                busy_q   <= 1'b1;
                remain_q <= len;
                rd_ptr_q <= src;
                wr_ptr_q <= dst;
            end else begin
                if (rd_en) begin
                    rd_ptr_q <= rd_ptr_q + ADDR_ONE;
                    remain_q <= remain_q - LEN_ONE;
                end
                if (wr_q) begin
                    wr_ptr_q <= wr_ptr_q + ADDR_ONE;
                end
                if (done) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Port views of the pipeline state.
    always_comb begin
        rd_addr = rd_ptr_q;
        wr_en   = wr_q;
        wr_addr = wr_ptr_q;
        wr_data = data_q;
    end

endmodule

// File: rtl/boot_mover_cfg.sv
// Module: boot_mover_cfg
// Holds the processor-mode configuration register. set_ovly ORs in the
// overlay bit and leaves every other bit alone. Assumes OVLY_BIT < CFG_W.
module boot_mover_cfg #(
    parameter int              CFG_W    = 16,
    parameter int              OVLY_BIT = 5,
    parameter logic [CFG_W-1:0] CFG_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_ovly,
    output logic [CFG_W-1:0] cfg
);

    localparam logic [CFG_W-1:0] OVLY_MASK = CFG_W'(1) << OVLY_BIT;

    logic [CFG_W-1:0] cfg_q;

    // Register update: load the initial value on reset, set overlay on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_INIT;
        end else if (set_ovly) begin
            cfg_q <= cfg_q | OVLY_MASK;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/boot_mover.sv
// Module: boot_mover (top)
// Boot copy engine: masks interrupts, copies the vector table from VEC_SRC
// and then the user program, sets the overlay bit and emits a jump.
// Assumes the segment inputs stay stable from reset release until the jump.
// One copy unit is shared by both phases, which never overlap.
module boot_mover
    import boot_mover_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter int               DATA_W   = 16,
    parameter int               LEN_W    = 16,
    parameter int               CFG_W    = 16,
    parameter int               OVLY_BIT = 5,
    parameter logic [ADDR_W-1:0] VEC_SRC  = 16'hFF80,
    parameter logic [CFG_W-1:0]  CFG_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vec_dst,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic [ADDR_W-1:0] prg_src,
    input  logic [ADDR_W-1:0] prg_dst,
    input  logic [LEN_W-1:0]  prg_len,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic [DATA_W-1:0] src_rd_data,
    output logic              dst_wr_en,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output logic [DATA_W-1:0] dst_wr_data,
    output logic [CFG_W-1:0]  mode_cfg,
    output logic              irq_mask,
    output logic              jump_valid,
    output logic [ADDR_W-1:0] jump_pc
);

    logic              xfer_start;
    logic              xfer_done;
    logic              sel_prg;
    logic              set_ovly;
    logic              jump_now;
    logic [ADDR_W-1:0] seg_src;
    logic [ADDR_W-1:0] seg_dst;
    logic [LEN_W-1:0]  seg_len;

    // Script sequencer.
    boot_mover_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_done  (xfer_done),
        .xfer_start (xfer_start),
        .sel_prg    (sel_prg),
        .set_ovly   (set_ovly),
        .jump_now   (jump_now),
        .irq_mask   (irq_mask)
    );

    // Segment descriptor for the active phase.
    always_comb begin
        seg_src = sel_prg ? prg_src : VEC_SRC;
        seg_dst = sel_prg ? prg_dst : vec_dst;
        seg_len = sel_prg ? prg_len : vec_len;
    end

    // Shared copy unit.
    boot_mover_xfer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .src     (seg_src),
        .dst     (seg_dst),
        .len     (seg_len),
        .rd_en   (src_rd_en),
        .rd_addr (src_rd_addr),
        .rd_data (src_rd_data),
        .wr_en   (dst_wr_en),
        .wr_addr (dst_wr_addr),
        .wr_data (dst_wr_data),
        .done    (xfer_done)
    );

    // Processor-mode configuration register.
    boot_mover_cfg #(
        .CFG_W    (CFG_W),
        .OVLY_BIT (OVLY_BIT),
        .CFG_INIT (CFG_INIT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ovly (set_ovly),
        .cfg      (mode_cfg)
    );

    // Jump outputs, with the target shown only while the strobe is high.
    always_comb begin
        jump_valid = jump_now;
        jump_pc    = jump_now ? prg_dst : '0;
    end

endmodule

// File: rtl/boot_mover_chk.sv
// Module: boot_mover_chk
// Port-level protocol checks for boot_mover, attached by bind below.
module boot_mover_chk #(
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 16,
    parameter int OVLY_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [CFG_W-1:0]  cfg,
    input logic              irq_mask,
    input logic              jump_valid
);

    logic jumped_q;

    // Remembers that the jump strobe has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          jumped_q <= 1'b0;
        else if (jump_valid) jumped_q <= 1'b1;
    end

    a_r2_mask_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> irq_mask);

    a_r5_write_two_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en, 2));

    a_r5_write_data_match: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == $past(rd_data)));

    a_r7_cfg_stable_copying: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> $stable(cfg));

    a_r8_jump_has_overlay: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |-> cfg[OVLY_BIT]);

    a_r8_jump_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> !jump_valid);

    a_r9_quiet_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
        jumped_q |-> (!rd_en && !wr_en && !jump_valid));

endmodule

bind boot_mover boot_mover_chk #(
    .DATA_W   (DATA_W),
    .CFG_W    (CFG_W),
    .OVLY_BIT (OVLY_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (src_rd_en),
    .rd_data    (src_rd_data),
    .wr_en      (dst_wr_en),
    .wr_data    (dst_wr_data),
    .cfg        (mode_cfg),
    .irq_mask   (irq_mask),
    .jump_valid (jump_valid)
);

// File: tb/boot_mover_bench.sv
// Bench: sweeps both segment lengths over 0..5 and checks every access,
// the configuration register and the exact jump cycle against arithmetic.
module boot_mover_bench;

    localparam logic [15:0] CFG_INIT = 16'h0003;
    localparam logic [15:0] VEC_SRC  = 16'hFF80;
    localparam logic [15:0] VEC_DST  = 16'h0080;
    localparam logic [15:0] PRG_SRC  = 16'h8100;
    localparam logic [15:0] PRG_DST  = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] vec_dst = VEC_DST;
    logic [15:0] vec_len = '0;
    logic [15:0] prg_src = PRG_SRC;
    logic [15:0] prg_dst = PRG_DST;
    logic [15:0] prg_len = '0;
    logic        src_rd_en;
    logic [15:0] src_rd_addr;
    logic [15:0] src_rd_data = '0;
    logic        dst_wr_en;
    logic [15:0] dst_wr_addr;
    logic [15:0] dst_wr_data;
    logic [15:0] mode_cfg;
    logic        irq_mask;
    logic        jump_valid;
    logic [15:0] jump_pc;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    boot_mover #(.CFG_INIT(CFG_INIT)) u_boot_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .vec_dst     (vec_dst),
        .vec_len     (vec_len),
        .prg_src     (prg_src),
        .prg_dst     (prg_dst),
        .prg_len     (prg_len),
        .src_rd_en   (src_rd_en),
        .src_rd_addr (src_rd_addr),
        .src_rd_data (src_rd_data),
        .dst_wr_en   (dst_wr_en),
        .dst_wr_addr (dst_wr_addr),
        .dst_wr_data (dst_wr_data),
        .mode_cfg    (mode_cfg),
        .irq_mask    (irq_mask),
        .jump_valid  (jump_valid),
        .jump_pc     (jump_pc)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return (a ^ 16'h5A3C) + 16'h0101;
    endfunction

    // Source memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (src_rd_en) src_rd_data <= mem_word(src_rd_addr);
    end

    function automatic int phase_len(input int n);
        return (n == 0) ? 1 : n + 3;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int nv, input int np);
        int rd_idx = 0;
        int wr_idx = 0;
        int rd_cyc [0:15];
        int jump_k = 4 + phase_len(nv) + phase_len(np);
        int seen_jump = 0;
        bit cfg_held = 1'b1;
        logic [15:0] exp_a;
        vec_len = 16'(nv);
        prg_len = 16'(np);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!src_rd_en && !dst_wr_en && !jump_valid, "R1", {29'd0, src_rd_en, dst_wr_en, jump_valid}, 0);
        chk(irq_mask == 1'b0 && mode_cfg == CFG_INIT, "R1", {15'd0, irq_mask, mode_cfg}, {16'd0, CFG_INIT});
        rst_n = 1'b1;
        for (int k = 0; k < jump_k + 8; k++) begin
            #2;
            if (k == 1) chk(irq_mask == 1'b1, "R2", irq_mask, 1);
            if (src_rd_en) begin
                chk(irq_mask == 1'b1, "R2", irq_mask, 1);
                if (rd_idx < nv) exp_a = VEC_SRC + 16'(rd_idx);
                else             exp_a = PRG_SRC + 16'(rd_idx - nv);
                chk(src_rd_addr == exp_a, rd_idx < nv ? "R3" : "R4", src_rd_addr, exp_a);
                // R4: program reads start only after the last vector write
                if (rd_idx == nv) chk(wr_idx == nv, "R4", wr_idx, nv);
                if (rd_idx < 16) rd_cyc[rd_idx] = k;
                rd_idx++;
            end
            if (dst_wr_en) begin
                if (wr_idx < nv) exp_a = VEC_DST + 16'(wr_idx);
                else             exp_a = PRG_DST + 16'(wr_idx - nv);
                chk(dst_wr_addr == exp_a, wr_idx < nv ? "R3" : "R4", dst_wr_addr, exp_a);
                if (wr_idx < nv) chk(dst_wr_data == mem_word(VEC_SRC + 16'(wr_idx)), "R5", dst_wr_data, mem_word(VEC_SRC + 16'(wr_idx)));
                else chk(dst_wr_data == mem_word(PRG_SRC + 16'(wr_idx - nv)), "R5", dst_wr_data, mem_word(PRG_SRC + 16'(wr_idx - nv)));
                if (wr_idx < 16 && wr_idx < rd_idx) chk(k == rd_cyc[wr_idx] + 2, "R5", k, rd_cyc[wr_idx] + 2);
                wr_idx++;
            end
            if (k < jump_k && mode_cfg != CFG_INIT) cfg_held = 1'b0;
            if (k == jump_k) begin
                chk(jump_valid == 1'b1, "R8", jump_valid, 1);
                chk(jump_pc == PRG_DST, "R8", jump_pc, PRG_DST);
                chk(mode_cfg == (CFG_INIT | 16'h0020), "R7", mode_cfg, CFG_INIT | 16'h0020);
                chk(cfg_held, "R7", cfg_held, 1);
                // R6: access counts per phase, zero lengths included
                chk(rd_idx == nv + np && wr_idx == nv + np, "R6", {rd_idx[15:0], wr_idx[15:0]}, {16'(nv + np), 16'(nv + np)});
            end else if (jump_valid) begin
                chk(1'b0, "R8", k, jump_k);
            end
            if (k > jump_k) begin
                if (src_rd_en || dst_wr_en || jump_valid) chk(1'b0, "R9", {src_rd_en, dst_wr_en, jump_valid}, 0);
            end
            if (jump_valid) seen_jump++;
            @(negedge clk);
        end
        chk(seen_jump == 1, "R9", seen_jump, 1);
        chk(mode_cfg == (CFG_INIT | 16'h0020), "R9", mode_cfg, CFG_INIT | 16'h0020);
    endtask

    initial begin
        @(negedge clk);
        for (int v = 0; v <= 5; v++) begin
            for (int p = 0; p <= 5; p++) begin
                run_case(v, p);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule